// File: doc/BRIEF.md
# Bounce Filter Bank

This block cleans up a group of slow, noisy inputs that arrive asynchronously, such as pushbuttons and slide switches, for logic that runs on one system clock. Each input first passes through a two-flop synchronizer. It then goes to its own small state machine, which accepts a new level only after the input has held that level for a whole settle window.

The settle window is not timed with a full-rate counter per channel. A single prescaler, shared by every channel, emits a one-cycle tick 2^CNT_BITS times per window. Each channel counts these ticks in a CNT_BITS-wide register. With the default six channels, 125 MHz and 25 ms, the design holds one 19-bit prescaler and six 3-bit counters, about 37 bits in total. Six separate full-rate counters would need about 132 bits.

Each channel drives a steady level and a one-cycle pulse on every accepted 0-to-1 change. One press therefore gives one pulse, which a downstream block can use directly as a write or read strobe.

Channel states: `ST_LOW` (accepted level 0, idle), `ST_RISE` (input is 1, ticks being counted toward accepting 1), `ST_HIGH` (accepted level 1, idle), `ST_FALL` (input is 0, ticks being counted toward accepting 0). The transitions are:
- LOW→RISE when the synchronized input is 1.
- RISE→LOW (abort) when the input returns to 0.
- RISE→HIGH (accept) on the tick that finds the counter at its maximum.
- HIGH→FALL when the input is 0.
- FALL→HIGH (abort) when the input returns to 1.
- FALL→LOW (accept) on the tick that finds the counter at its maximum.

Top module: `bounce_filter_bank`

## Requirements
- R1: A synchronous active-high `rst` drives every `level_o` bit and every `rise_o` bit to 0 at the next clock edge. It holds them at 0 whatever `raw_i` does. Releasing `rst` with every `raw_i` bit at 0 produces no pulse.
- R2: After `raw_i[k]` changes from 0 to 1 and then holds, `level_o[k]` becomes 1. This happens no earlier than (2^CNT_BITS−1)·TICK_DIV cycles and no later than 2^CNT_BITS·TICK_DIV+4 cycles after the change. TICK_DIV is CLK_HZ·SETTLE_US/10^6 shifted right by CNT_BITS.
- R3: After `raw_i[k]` changes from 1 to 0 and then holds, `level_o[k]` becomes 0 within the same window as in R2.
- R4: If the synchronized input returns to the accepted level before acceptance, the qualification starts over. A high or low stretch shorter than (2^CNT_BITS−1)·TICK_DIV cycles, repeated any number of times, leaves `level_o[k]` unchanged.
- R5: `rise_o[k]` is 1 for exactly one cycle, in the first cycle that `level_o[k]` reads 1 after reading 0. One held press preceded by any amount of bounce gives exactly one pulse.
- R6: A 1-to-0 change of `level_o[k]` produces no pulse on `rise_o[k]`.
- R7: Channels are independent. Stimulus on `raw_i[k]` changes neither `level_o[j]` nor `rise_o[j]` for j≠k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_i | input | N_CH | Asynchronous raw inputs, one bit per channel |
| level_o | output | N_CH | Debounced level per channel |
| rise_o | output | N_CH | One-cycle pulse on each accepted 0-to-1 change |

## Verification
The assertions assume that `raw_i` reaches each channel only through its synchronizer. They also assume that `rst` is held for at least one clock edge before any history is judged, so every `$past` term refers to cycles after reset. The bench keeps within this by holding `rst` for several cycles at start. It changes `raw_i` only on falling clock edges, and it never pulses `rst` for less than a full cycle. Bounce trains use stretches of 20 cycles, well below one tick period, so that rejection (R4) and acceptance (R2, R5) are separated by a clear margin rather than by a single tick.

// File: rtl/bfb_pkg.sv
package bfb_pkg;

    typedef enum logic [1:0] {
        ST_LOW  = 2'd0,
        ST_RISE = 2'd1,
        ST_HIGH = 2'd2,
        ST_FALL = 2'd3
    } bfb_state_e;

endpackage

// File: rtl/bfb_sync.sv
module bfb_sync #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;

endmodule

// File: rtl/bfb_tick.sv
module bfb_tick #(
    parameter int DIV = 390625
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] div_q;

    assign tick_o = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + ONE;
        end
    end

    generate
        if (DIV > 1) begin : g_gap_chk
            // The shared tick never comes on two cycles in a row (timing window of R2/R3)
            assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/bfb_chan.sv
module bfb_chan
    import bfb_pkg::*;
#(
    parameter int CNT_BITS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_i,
    input  logic tick_i,
    output logic level_o,
    output logic rise_o
);

    localparam logic [CNT_BITS-1:0] CMAX = '1;
    localparam logic [CNT_BITS-1:0] ONE  = CNT_BITS'(1);

    bfb_state_e          st_q, st_d;
    logic [CNT_BITS-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_LOW: begin
                cnt_d = '0;
                if (smp_i) st_d = ST_RISE;
            end
            ST_RISE: begin
                if (!smp_i) begin
                    st_d  = ST_LOW;
                    cnt_d = '0;
                end else if (tick_i) begin
                    if (cnt_q == CMAX) begin
                        st_d  = ST_HIGH;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
            end
            ST_HIGH: begin
                cnt_d = '0;
                if (!smp_i) st_d = ST_FALL;
            end
            ST_FALL: begin
                if (smp_i) begin
                    st_d  = ST_HIGH;
                    cnt_d = '0;
                end else if (tick_i) begin
                    if (cnt_q == CMAX) begin
                        st_d  = ST_LOW;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_LOW;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            level_o <= 1'b0;
            rise_o  <= 1'b0;
        end else begin
            level_o <= (st_d == ST_HIGH) || (st_d == ST_FALL);
            rise_o  <= (st_q == ST_RISE) && (st_d == ST_HIGH);
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!level_o && !rise_o));

    assert_rise_from_qualify_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(level_o) |-> ($past(st_q) == ST_RISE));

    assert_fall_from_qualify_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(level_o) |-> ($past(st_q) == ST_FALL));

    assert_idle_cnt_clear_R4: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_LOW) || (st_q == ST_HIGH)) |-> (cnt_q == '0));

    assert_pulse_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
        rise_o |-> (level_o && !$past(level_o)));

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

    assert_no_pulse_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(level_o) |-> !rise_o);

endmodule

// File: rtl/bounce_filter_bank.sv
module bounce_filter_bank #(
    parameter int N_CH      = 6,
    parameter int CLK_HZ    = 125_000_000,
    parameter int SETTLE_US = 25_000,
    parameter int CNT_BITS  = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] raw_i,
    output logic [N_CH-1:0] level_o,
    output logic [N_CH-1:0] rise_o
);

    localparam longint SETTLE_CYC = (longint'(CLK_HZ) * longint'(SETTLE_US)) / 64'sd1000000;
    localparam longint DIV_RAW    = SETTLE_CYC >>> CNT_BITS;
    localparam int     TICK_DIV   = (DIV_RAW < 64'sd1) ? 1 : int'(DIV_RAW);

    logic [N_CH-1:0] smp;
    logic            tick;

    bfb_sync #(.WIDTH(N_CH)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_i),
        .sync_o  (smp)
    );

    bfb_tick #(.DIV(TICK_DIV)) i_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    generate
        for (genvar k = 0; k < N_CH; k++) begin : g_ch
            bfb_chan #(.CNT_BITS(CNT_BITS)) i_chan (
                .clk     (clk),
                .rst     (rst),
                .smp_i   (smp[k]),
                .tick_i  (tick),
                .level_o (level_o[k]),
                .rise_o  (rise_o[k])
            );
        end
    endgenerate

endmodule

// File: tb/test_bounce_filter_bank.sv
`timescale 1ns/1ps
module test_bounce_filter_bank;

    localparam int N_CH = 6;
    localparam int CB   = 3;
    localparam int DIV  = (250 >> CB);          // 250 MHz, 1 us settle -> 31
    localparam int MIN_ACC = ((1 << CB) - 1) * DIV;
    localparam int MAX_ACC = (1 << CB) * DIV + 4;

    typedef struct packed {
        logic [2:0]  ch;
        logic        tgt;
        logic [3:0]  ng;
        logic [15:0] hold;
        logic        xl;
        logic [1:0]  xp;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{3'd0, 1'b1, 4'd3, 16'd300, 1'b1, 2'd1},
        '{3'd0, 1'b0, 4'd2, 16'd300, 1'b0, 2'd0},
        '{3'd1, 1'b1, 4'd0, 16'd150, 1'b0, 2'd0},
        '{3'd1, 1'b1, 4'd5, 16'd300, 1'b1, 2'd1},
        '{3'd2, 1'b1, 4'd0, 16'd300, 1'b1, 2'd1},
        '{3'd2, 1'b0, 4'd0, 16'd150, 1'b1, 2'd0},
        '{3'd5, 1'b1, 4'd2, 16'd300, 1'b1, 2'd1},
        '{3'd5, 1'b0, 4'd0, 16'd300, 1'b0, 2'd0},
        '{3'd3, 1'b1, 4'd8, 16'd300, 1'b1, 2'd1},
        '{3'd4, 1'b1, 4'd1, 16'd150, 1'b0, 2'd0}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N_CH-1:0] raw_i = '0;
    logic [N_CH-1:0] level_o;
    logic [N_CH-1:0] rise_o;

    int checks = 0;
    int fails  = 0;
    int pcnt [N_CH];
    logic [N_CH-1:0] prev_lvl = '0;
    logic [N_CH-1:0] prev_rise = '0;
    bit done = 0;

    always #2 clk = ~clk;

    bounce_filter_bank #(
        .N_CH(N_CH), .CLK_HZ(250_000_000), .SETTLE_US(1), .CNT_BITS(CB)
    ) i_bounce_filter_bank (
        .clk(clk), .rst(rst), .raw_i(raw_i), .level_o(level_o), .rise_o(rise_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pulse monitor: shape and coincidence of rise pulses (R5, R6)
    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CH; i++) pcnt[i] = 0;
            prev_lvl  <= '0;
            prev_rise <= '0;
        end else begin
            for (int i = 0; i < N_CH; i++) begin
                if (rise_o[i]) begin
                    pcnt[i] = pcnt[i] + 1;
                    chk("R5 pulse with 0->1 level", int'({level_o[i], prev_lvl[i]}), 2);
                    chk("R5 pulse width one cycle", int'(prev_rise[i]), 0);
                end
                if (prev_lvl[i] && !level_o[i])
                    chk("R6 no pulse on fall", int'(rise_o[i]), 0);
            end
            prev_lvl  <= level_o;
            prev_rise <= rise_o;
        end
    end

    initial begin
        #(4ns * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int snap [N_CH];
        // R1: reset holds outputs low even with all inputs high
        raw_i = '1;
        cyc(300);
        chk("R1 level in reset", int'(level_o), 0);
        chk("R1 pulse in reset", int'(rise_o), 0);
        raw_i = '0;
        cyc(5);
        rst = 1'b0;
        cyc(300);
        chk("R1 level after release", int'(level_o), 0);
        chk("R1 no pulse on release", pcnt[0] + pcnt[1] + pcnt[2] + pcnt[3] + pcnt[4] + pcnt[5], 0);

        // Vector table
        foreach (VEC[v]) begin
            automatic vec_t e = VEC[v];
            automatic int c = int'(e.ch);
            for (int j = 0; j < N_CH; j++) snap[j] = pcnt[j];
            for (int g = 0; g < int'(e.ng); g++) begin
                raw_i[c] = e.tgt;  cyc(20);
                raw_i[c] = ~e.tgt; cyc(20);
            end
            raw_i[c] = e.tgt;
            cyc(int'(e.hold));
            raw_i[c] = e.xl;
            cyc(10);
            chk(e.hold < 16'd200 ? "R4 short stretch rejected" : "R2/R3 level accepted",
                int'(level_o[c]), int'(e.xl));
            chk(e.tgt ? "R5 pulses per press" : "R6 pulses on release",
                pcnt[c] - snap[c], int'(e.xp));
            for (int j = 0; j < N_CH; j++)
                if (j != c) chk("R7 other channel quiet", pcnt[j] - snap[j], 0);
        end

        // R2 window on channel 4 (currently low)
        raw_i[4] = 1'b1;
        cyc(MIN_ACC - 5);
        chk("R2 not before window", int'(level_o[4]), 0);
        cyc(MAX_ACC - MIN_ACC + 10);
        chk("R2 accepted by window end", int'(level_o[4]), 1);

        // R3 window on channel 4
        raw_i[4] = 1'b0;
        cyc(MIN_ACC - 5);
        chk("R3 not before window", int'(level_o[4]), 1);
        cyc(MAX_ACC - MIN_ACC + 10);
        chk("R3 accepted by window end", int'(level_o[4]), 0);

        // R1: reset in the middle of operation (channels 1,2,3 are high)
        chk("R1 precondition high", int'(level_o[2]), 1);
        rst = 1'b1;
        cyc(1);
        chk("R1 mid-run reset clears", int'(level_o), 0);
        raw_i = '0;
        cyc(3);
        rst = 1'b0;
        cyc(300);
        chk("R1 quiet after mid-run reset", pcnt[0] + pcnt[1] + pcnt[2] + pcnt[3] + pcnt[4] + pcnt[5], 0);
        chk("R1 levels stay low", int'(level_o), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule